// File: doc/BRIEF.md
# Supply Voltage Supervisor Interrupt Controller

This block is the digital side of a supply monitor. An analog comparator, outside the block, compares the supply against a selectable threshold. Its output arrives here asynchronously, at logic 1 while the supply is below the threshold. A small write/read register interface configures the monitor. The threshold select goes straight out to the analog side. Enabling the monitor starts a settle period. After it the block raises a ready flag, tracks the under-voltage state in a status flag, and emits a one-cycle interrupt pulse each time that state changes in either direction.

Detection runs only for one configuration: direct comparator path (no filtering), interrupt function, and a supervisor mode. Any other configuration keeps the block idle. Disabling the monitor, or leaving that configuration, drops ready, status and interrupt at once. A later enable restarts the full settle period.

Top module: `vsup_irq_ctrl`

## Requirements
- R1: After reset, all configuration fields are 0, `rdData` reads 0 at every address, and `cmpEnable`, `levelSel`, `readyOut`, `underVolt` and `irqPulse` are 0.
- R2: A write to address 1 stores `wrData[3:0]` as the threshold select. It appears on `levelSel` in the cycle after the write edge and reads back at address 1. Upper data bits are dropped.
- R3: Address 2 bits [1:0] hold the sampling mode. Address 3 bits [1:0] hold the operating mode and bits [3:2] the function select. All three read back as written.
- R4: Detection is armed only when the enable bit (address 0 bit 0) is 1, the operating mode is 2'b10 or 2'b11, the sampling mode is 2'b00 (direct) and the function select is 2'b00 (interrupt). Otherwise `readyOut` stays 0.
- R5: Once armed by a write edge, `readyOut` stays 0 for STAB_CYCLES cycles after that edge. It becomes 1 in the cycle after the next edge, STAB_CYCLES+1 edges after the write.
- R6: While `readyOut` is 0, `underVolt` and `irqPulse` stay 0 whatever `cmpIn` does.
- R7: While ready, `underVolt` equals `cmpIn` as it was three clock edges earlier (two synchronizer stages plus the status register).
- R8: `irqPulse` is high for exactly the cycles in which `underVolt` differs from its value in the previous ready cycle. This covers both the falling-below and the rising-back transitions.
- R9: When `readyOut` rises, `underVolt` takes the current synchronized comparator value, and no interrupt pulse is produced for it.
- R10: Clearing the enable bit drops `cmpEnable`, `readyOut`, `underVolt` and `irqPulse` to 0 in the cycle after the write edge. Comparator activity while disabled raises no pulse. Re-enabling repeats the full settle period of R5.
- R11: Address 0 reads enable in bit 0, ready in bit 1 and under-voltage status in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| cmpIn | input | 1 | Asynchronous comparator result, 1 = supply below threshold |
| cmpEnable | output | 1 | Enable bit driven to the analog comparator |
| levelSel | output | 4 | Threshold select driven to the analog comparator |
| readyOut | output | 1 | Settle period over, detection live |
| underVolt | output | 1 | Tracked under-voltage status |
| irqPulse | output | 1 | One-cycle interrupt on each status change |

## Verification
A stuck or miscounted settle counter shows as `readyOut` rising one or more cycles early or late after the enable write edge. The bench checks that every cycle. A synchronizer of the wrong depth or a lost status update moves `underVolt` off the three-edge alignment with `cmpIn` within four cycles of a comparator change. A wrong interrupt compare shows as a missing, doubled or spurious `irqPulse` in the same cycle. A sequencer left running after a disable or a configuration change shows in the very next cycle as a nonzero ready or status output.

// File: rtl/vsup_pkg.sv
package vsup_pkg;

  // register addresses
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_LEVEL  = 2'd1;
  localparam logic [1:0] ADDR_SAMPLE = 2'd2;
  localparam logic [1:0] ADDR_MODE   = 2'd3;

  // field encodings that arm the detection path
  localparam logic [1:0] SAMPLE_DIRECT  = 2'b00;
  localparam logic [1:0] FUNC_INTERRUPT = 2'b00;

  typedef enum logic [1:0] {
    StIdle   = 2'd0,
    StSettle = 2'd1,
    StRun    = 2'd2
  } ctrlState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic live;      // configuration armed, outputs may show
    logic clear;     // wipe counter, ready, status, interrupt
    logic cntInc;    // advance settle counter
    logic loadInit;  // settle over: set ready, load status silently
    logic track;     // follow comparator and pulse on change
  } dpStrobes_t;

endpackage

// File: rtl/vsup_regs.sv
module vsup_regs
  import vsup_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LEVEL_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               readyIn,
  input  logic               statusIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               enable,
  output logic [LEVEL_W-1:0] level,
  output logic [1:0]         sampleMode,
  output logic [1:0]         opMode,
  output logic [1:0]         funcSel,
  output logic               armed
);

  logic unusedHiBits;
  assign unusedHiBits = ^wrData[DATA_W-1:LEVEL_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable     <= 1'b0;
      level      <= '0;
      sampleMode <= '0;
      opMode     <= '0;
      funcSel    <= '0;
    end else if (wrEn) begin
      unique case (addr)
        ADDR_CTRL:   enable     <= wrData[0];
        ADDR_LEVEL:  level      <= wrData[LEVEL_W-1:0];
        ADDR_SAMPLE: sampleMode <= wrData[1:0];
        ADDR_MODE: begin
          opMode  <= wrData[1:0];
          funcSel <= wrData[3:2];
        end
        default: ;
      endcase
    end
  end

  assign armed = enable && opMode[1] &&
                 (sampleMode == SAMPLE_DIRECT) &&
                 (funcSel == FUNC_INTERRUPT);

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_CTRL:   rdData[2:0] = {statusIn, readyIn, enable};
      ADDR_LEVEL:  rdData[LEVEL_W-1:0] = level;
      ADDR_SAMPLE: rdData[1:0] = sampleMode;
      ADDR_MODE:   rdData[3:0] = {funcSel, opMode};
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/vsup_ctrl.sv
module vsup_ctrl
  import vsup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armed,
  input  logic       cntDone,
  output dpStrobes_t strobes
);

  ctrlState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= StIdle;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD       = stateQ;
    strobes      = '0;
    strobes.live = armed;
    if (!armed) begin
      strobes.clear = 1'b1;
      stateD        = StIdle;
    end else begin
      unique case (stateQ)
        StIdle: begin
          strobes.clear = 1'b1;
          stateD        = StSettle;
        end
        StSettle: begin
          if (cntDone) begin
            strobes.loadInit = 1'b1;
            stateD           = StRun;
          end else begin
            strobes.cntInc = 1'b1;
          end
        end
        StRun: strobes.track = 1'b1;
        default: begin
          strobes.clear = 1'b1;
          stateD        = StIdle;
        end
      endcase
    end
  end

endmodule

// File: rtl/vsup_datapath.sv
module vsup_datapath
  import vsup_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmpIn,
  input  dpStrobes_t strobes,
  output logic       cntDone,
  output logic       readyOut,
  output logic       statusOut,
  output logic       irqOut
);

  localparam int unsigned CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   cmpSync;
  logic [CNT_W-1:0]       settleCnt;
  logic                   readyQ, statusQ, irqQ;

  // comparator synchronizer chain
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= cmpIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  assign cmpSync = syncQ[SYNC_STAGES-1];
  assign cntDone = (settleCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
      readyQ    <= 1'b0;
      statusQ   <= 1'b0;
      irqQ      <= 1'b0;
    end else if (strobes.clear) begin
      settleCnt <= '0;
      readyQ    <= 1'b0;
      statusQ   <= 1'b0;
      irqQ      <= 1'b0;
    end else begin
      if (strobes.cntInc) settleCnt <= settleCnt + 1'b1;
      if (strobes.loadInit) begin
        readyQ  <= 1'b1;
        statusQ <= cmpSync;
      end
      if (strobes.track) statusQ <= cmpSync;
      irqQ <= strobes.track && (statusQ != cmpSync);
    end
  end

  // outputs vanish the cycle the configuration is no longer armed
  assign readyOut  = readyQ  && strobes.live;
  assign statusOut = statusQ && strobes.live;
  assign irqOut    = irqQ    && strobes.live;

endmodule

// File: rtl/vsup_irq_ctrl.sv
module vsup_irq_ctrl
  import vsup_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned LEVEL_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic               cmpIn,
  output logic               cmpEnable,
  output logic [LEVEL_W-1:0] levelSel,
  output logic               readyOut,
  output logic               underVolt,
  output logic               irqPulse
);

  dpStrobes_t strobes;
  logic       armed, cntDone;
  logic [1:0] sampleMode, opMode, funcSel;

  vsup_regs #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .readyIn   (readyOut),
    .statusIn  (underVolt),
    .rdData    (rdData),
    .enable    (cmpEnable),
    .level     (levelSel),
    .sampleMode(sampleMode),
    .opMode    (opMode),
    .funcSel   (funcSel),
    .armed     (armed)
  );

  vsup_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .armed  (armed),
    .cntDone(cntDone),
    .strobes(strobes)
  );

  vsup_datapath #(.STAB_CYCLES(STAB_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmpIn    (cmpIn),
    .strobes  (strobes),
    .cntDone  (cntDone),
    .readyOut (readyOut),
    .statusOut(underVolt),
    .irqOut   (irqPulse)
  );

endmodule

// File: rtl/vsup_irq_ctrl_checker.sv
module vsup_irq_ctrl_checker #(
  parameter int unsigned LEVEL_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [1:0]         addr,
  input logic               cmpEnable,
  input logic [LEVEL_W-1:0] levelSel,
  input logic               readyOut,
  input logic               underVolt,
  input logic               irqPulse
);

  AST_IRQ_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (underVolt != $past(underVolt))); // R8

  AST_CHANGE_MEANS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (readyOut && $past(readyOut) && (underVolt != $past(underVolt))) |-> irqPulse); // R8

  AST_NO_IRQ_UNREADY: assert property (@(posedge clk) disable iff (!rstN)
    !readyOut |-> !irqPulse); // R6

  AST_STATUS_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    underVolt |-> readyOut); // R6

  AST_NO_IRQ_ON_READY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyOut) |-> !irqPulse); // R9

  AST_READY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    readyOut |-> cmpEnable); // R10

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == 2'd1) |=> $stable(levelSel)); // R2

endmodule

bind vsup_irq_ctrl vsup_irq_ctrl_checker #(.LEVEL_W(LEVEL_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .cmpEnable(cmpEnable),
  .levelSel (levelSel),
  .readyOut (readyOut),
  .underVolt(underVolt),
  .irqPulse (irqPulse)
);

// File: tb/vsup_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vsup_irq_ctrl_bench;

  localparam int STAB = 5;
  localparam int PLEN = 16;
  localparam logic [PLEN-1:0] PAT = 16'b0110_0011_1010_0100;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       cmpIn = 1'b0;
  logic       cmpEnable, readyOut, underVolt, irqPulse;
  logic [3:0] levelSel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vsup_irq_ctrl #(.STAB_CYCLES(STAB)) u_vsup_irq_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cmpIn(cmpIn), .cmpEnable(cmpEnable), .levelSel(levelSel),
    .readyOut(readyOut), .underVolt(underVolt), .irqPulse(irqPulse)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  function automatic logic patAt(input int i);
    if (i < 0) return 1'b0;
    if (i >= PLEN) return PAT[PLEN-1];
    return PAT[i];
  endfunction

  // settle window check: ready low for STAB cycles after write edge, then high
  task automatic settleCheck(input string req);
    for (int k = 0; k <= STAB + 1; k++) begin
      chk(req, {7'd0, readyOut}, {7'd0, k == STAB + 1});
      if (k <= STAB) begin
        chk("R6 status low while settling", {7'd0, underVolt}, 8'd0);
        chk("R6 no irq while settling", {7'd0, irqPulse}, 8'd0);
        @(negedge clk);
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 cmpEnable", {7'd0, cmpEnable}, 8'd0);
    chk("R1 levelSel", {4'd0, levelSel}, 8'd0);
    chk("R1 ready", {7'd0, readyOut}, 8'd0);
    chk("R1 status", {7'd0, underVolt}, 8'd0);
    chk("R1 irq", {7'd0, irqPulse}, 8'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk("R1 readback", r, 8'd0);
    end

    // R2: level select sweep, upper bits dropped
    for (int l = 0; l < 16; l++) begin
      wr(2'd1, 8'(8'hA0 | l));
      chk("R2 levelSel", {4'd0, levelSel}, 8'(l));
      rd(2'd1, r);
      chk("R2 level readback", r, 8'(l));
    end

    // R3, R4: full configuration sweep
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int f = 0; f < 4; f++) begin
          wr(2'd2, 8'(s));
          wr(2'd3, 8'((f << 2) | m));
          wr(2'd0, 8'd1);
          chk("R4 ready low right after enable", {7'd0, readyOut}, 8'd0);
          repeat (STAB + 2) @(negedge clk);
          chk("R4 armed config", {7'd0, readyOut},
              {7'd0, (m >= 2) && (s == 0) && (f == 0)});
          rd(2'd2, r);
          chk("R3 sample readback", r, 8'(s));
          rd(2'd3, r);
          chk("R3 mode readback", r, 8'((f << 2) | m));
          wr(2'd0, 8'd0);
        end
      end
    end

    // R5: exact settle timing
    wr(2'd2, 8'd0);
    wr(2'd3, 8'd2);
    wr(2'd0, 8'd1);
    settleCheck("R5 settle timing");
    rd(2'd0, r);
    chk("R11 ctrl readback", r, 8'h03);

    // R7, R8: comparator pattern
    for (int n = 0; n < PLEN + 5; n++) begin
      chk("R7 status delay", {7'd0, underVolt}, {7'd0, patAt(n - 3)});
      chk("R8 irq on change", {7'd0, irqPulse}, {7'd0, patAt(n - 3) != patAt(n - 4)});
      rd(2'd0, r);
      chk("R11 status bit", {7'd0, r[2]}, {7'd0, patAt(n - 3)});
      cmpIn = patAt(n);
      @(negedge clk);
    end

    // R4: leaving supervisor mode while running drops ready at once
    wr(2'd3, 8'd1);
    chk("R4 mode change drops ready", {7'd0, readyOut}, 8'd0);
    wr(2'd3, 8'd3);
    settleCheck("R4 mode 3 settles");

    // R9: under-voltage already present when ready rises
    wr(2'd0, 8'd0);
    cmpIn = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'd1);
    settleCheck("R9 settle with low supply");
    chk("R9 status loaded", {7'd0, underVolt}, 8'd1);
    chk("R9 no irq at ready", {7'd0, irqPulse}, 8'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 no later irq", {7'd0, irqPulse}, 8'd0);
    end

    // R10: disable clears immediately, restart repeats settle
    wr(2'd0, 8'd0);
    chk("R10 cmpEnable", {7'd0, cmpEnable}, 8'd0);
    chk("R10 ready", {7'd0, readyOut}, 8'd0);
    chk("R10 status", {7'd0, underVolt}, 8'd0);
    chk("R10 irq", {7'd0, irqPulse}, 8'd0);
    for (int k = 0; k < 8; k++) begin
      cmpIn = k[0];
      @(negedge clk);
      chk("R10 no irq while disabled", {7'd0, irqPulse}, 8'd0);
    end
    cmpIn = 1'b0;
    repeat (3) @(negedge clk);
    wr(2'd0, 8'd1);
    settleCheck("R10 restart settle");
    chk("R10 status after restart", {7'd0, underVolt}, 8'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule